// File: doc/BRIEF.md
# Event-Decimating Interrupt Counter

This block raises an interrupt request once every n counting events inside a three-phase PWM timer group. The count n is written through a load strobe and held in a reload register. Counting events come from one of two places. The first is the underflow pulse of the carrier timer. The second is a chosen edge of the reload control signal of a second timer. Two mode bits and an edge-polarity bit select the source.

When the block counts falling edges of the reload signal, the first interrupt after a load comes one event early: it fires after n-1 events. Every later interrupt fires after the full n events. A programmed count of zero acts as one. The counter runs only while the three-phase function is enabled. The result is a one-clock interrupt pulse that a downstream interrupt controller consumes.

Top module: `dic_irq_decim`

## Requirements
- R1: With `ext_mode` = 0, each clock with `car_uflow` = 1 is one event, whatever `src_sel` and `edge_pol` hold. Changes on `reload_sig` are not counted.
- R2: With `ext_mode` = 1 and `src_sel` = 0, each clock with `car_uflow` = 1 is one event.
- R3: With `ext_mode` = 1, `src_sel` = 1 and `edge_pol` = 0, each 0-to-1 change of `reload_sig` is one event. Falling changes and `car_uflow` pulses are not counted.
- R4: With `ext_mode` = 1, `src_sel` = 1 and `edge_pol` = 1, each 1-to-0 change of `reload_sig` is one event. Rising changes are not counted.
- R5: In the R4 configuration, the first interrupt after a load fires on event n-1 and later interrupts fire every n events. In every other configuration, every period is n events.
- R6: A loaded count of 0 behaves as 1. If the shortened first period would be 0 events, it is held at 1 event.
- R7: `irq_pulse` is high for exactly the one clock after the edge that samples the terminal event. On that same edge the count restarts from zero.
- R8: While `func_en` = 0, `irq_pulse` stays 0, counting progress is cleared, and the shortened first period is armed again.
- R9: A clock with `cnt_load` = 1 captures `cnt_val`, clears progress and arms the first period again. An event in that same clock is not counted.
- R10: During reset `irq_pulse` is 0. The level of `reload_sig` at reset release is taken as the baseline, so it does not count as an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| func_en | input | 1 | Three-phase function enable |
| ext_mode | input | 1 | 0 selects basic mode, 1 selects extended mode |
| src_sel | input | 1 | In extended mode, 1 selects the reload-signal edge as the source |
| edge_pol | input | 1 | Reload-signal edge: 0 selects rising, 1 selects falling |
| cnt_val | input | CNT_W | Count value n to load |
| cnt_load | input | 1 | Load strobe for `cnt_val` |
| car_uflow | input | 1 | Carrier-timer underflow pulse |
| reload_sig | input | 1 | Reload control level from the second timer |
| irq_pulse | output | 1 | One-clock interrupt request |

## Verification
A corrupted progress count or first-period flag has only one visible effect: the interrupt fires at the wrong event. The error therefore shows on the first interrupt after the fault, up to n events later. A wrong edge baseline or a wrong source choice shows sooner, as a pulse on an event that must be ignored. Each scenario therefore samples `irq_pulse` after every single event, and also after every ignored edge or pulse. This catches both an extra pulse and a missing one at the exact event where it occurs.

// File: rtl/dic_pkg.sv
package dic_pkg;

  typedef enum logic [1:0] {
    SRC_CARRIER = 2'd0,
    SRC_RISE    = 2'd1,
    SRC_FALL    = 2'd2
  } dic_src_e;

  // Source choice from the three mode inputs.
  function automatic dic_src_e pick_source(input logic ext, input logic sel, input logic pol);
    if (!ext || !sel) return SRC_CARRIER;
    return pol ? SRC_FALL : SRC_RISE;
  endfunction

  // Only falling-edge counting shortens the first period.
  function automatic logic shortens_first(input dic_src_e src);
    return (src == SRC_FALL);
  endfunction

endpackage

// File: rtl/dic_event_sel.sv
module dic_event_sel
  import dic_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ext_mode,
  input  logic src_sel,
  input  logic edge_pol,
  input  logic car_uflow,
  input  logic reload_sig,
  output logic evt,
  output logic short_mode
);

  logic     prev_q;
  logic     rise_w;
  logic     fall_w;
  dic_src_e src_w;

  // Baseline follows the live level during reset, so release adds no edge.
  always_ff @(posedge clk) begin
    prev_q <= reload_sig;
  end

  assign rise_w = reload_sig & ~prev_q;
  assign fall_w = ~reload_sig & prev_q;
  assign src_w  = pick_source(ext_mode, src_sel, edge_pol);

  always_comb begin
    case (src_w)
      SRC_RISE: evt = rise_w;
      SRC_FALL: evt = fall_w;
      default:  evt = car_uflow;
    endcase
  end

  assign short_mode = shortens_first(src_w);

  // R3
  rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && src_sel && !edge_pol && evt) |-> $rose(reload_sig));

  // R4
  fall_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_mode && src_sel && edge_pol && evt) |-> $fell(reload_sig));

endmodule

// File: rtl/dic_count_core.sv
module dic_count_core #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic             evt,
  input  logic             short_mode,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_load,
  output logic             irq_pulse
);

  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] prog_q;
  logic             first_q;
  logic             irq_q;
  logic [CNT_W-1:0] nxt_w;
  logic [CNT_W-1:0] target_w;
  logic             hit_w;

  function automatic logic [CNT_W-1:0] eff_count(input logic [CNT_W-1:0] v);
    return (v == '0) ? ONE : v;
  endfunction

  function automatic logic [CNT_W-1:0] period_target(input logic [CNT_W-1:0] n,
                                                     input logic first, input logic shrt);
    return (first && shrt && n > ONE) ? n - ONE : n;
  endfunction

  assign nxt_w    = prog_q + ONE;
  assign target_w = period_target(reload_q, first_q, short_mode);
  assign hit_w    = evt && (nxt_w >= target_w);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      reload_q <= ONE;
      prog_q   <= '0;
      first_q  <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      if (cnt_load) begin
        reload_q <= eff_count(cnt_val);
        prog_q   <= '0;
        first_q  <= 1'b1;
      end else if (!func_en) begin
        prog_q  <= '0;
        first_q <= 1'b1;
      end else if (evt) begin
        if (hit_w) begin
          prog_q  <= '0;
          first_q <= 1'b0;
          irq_q   <= 1'b1;
        end else begin
          prog_q <= nxt_w;
        end
      end
    end
  end

  assign irq_pulse = irq_q;

  // R7
  irq_after_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_q |-> $past(evt));

  // R8
  idle_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !func_en |=> !irq_q);

  // R9
  load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_load |=> !irq_q);

  // R6
  prog_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reload_q != '0) && (prog_q < reload_q));

endmodule

// File: rtl/dic_irq_decim.sv
module dic_irq_decim #(
  parameter int unsigned CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             func_en,
  input  logic             ext_mode,
  input  logic             src_sel,
  input  logic             edge_pol,
  input  logic [CNT_W-1:0] cnt_val,
  input  logic             cnt_load,
  input  logic             car_uflow,
  input  logic             reload_sig,
  output logic             irq_pulse
);

  logic evt_w;
  logic short_w;

  dic_event_sel u_sel (
    .clk        (clk),
    .rst_n      (rst_n),
    .ext_mode   (ext_mode),
    .src_sel    (src_sel),
    .edge_pol   (edge_pol),
    .car_uflow  (car_uflow),
    .reload_sig (reload_sig),
    .evt        (evt_w),
    .short_mode (short_w)
  );

  dic_count_core #(.CNT_W(CNT_W)) u_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .func_en    (func_en),
    .evt        (evt_w),
    .short_mode (short_w),
    .cnt_val    (cnt_val),
    .cnt_load   (cnt_load),
    .irq_pulse  (irq_pulse)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> !irq_pulse);

endmodule

// File: tb/sim_dic_irq_decim.sv
module sim_dic_irq_decim;
  localparam int CLK_P = 10;

  logic       clk = 1'b0;
  logic       rst_n, func_en, ext_mode, src_sel, edge_pol, cnt_load, car_uflow, reload_sig;
  logic [7:0] cnt_val;
  logic       irq_pulse;
  int         n_chk = 0;
  int         n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  dic_irq_decim #(.CNT_W(8)) u0 (
    .clk(clk), .rst_n(rst_n), .func_en(func_en), .ext_mode(ext_mode),
    .src_sel(src_sel), .edge_pol(edge_pol), .cnt_val(cnt_val), .cnt_load(cnt_load),
    .car_uflow(car_uflow), .reload_sig(reload_sig), .irq_pulse(irq_pulse)
  );

  task automatic check(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq_pulse actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  function automatic logic exp_hit(input int i, input int first, input int per);
    return (i == first) || (i > first && ((i - first) % per) == 0);
  endfunction

  task automatic car_step(input string req, input logic exp);
    @(negedge clk) car_uflow = 1'b1;
    @(negedge clk) car_uflow = 1'b0;
    check(req, irq_pulse, exp);
  endtask

  task automatic rl_step(input logic v, input string req, input logic exp);
    @(negedge clk) reload_sig = v;
    @(negedge clk);
    check(req, irq_pulse, exp);
  endtask

  task automatic set_mode(input logic e, input logic s, input logic p);
    @(negedge clk);
    ext_mode = e; src_sel = s; edge_pol = p;
  endtask

  task automatic do_load(input logic [7:0] v);
    @(negedge clk) cnt_val = v; cnt_load = 1'b1;
    @(negedge clk) cnt_load = 1'b0;
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check("R10 in reset", irq_pulse, 1'b0);
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 baseline", irq_pulse, 1'b0);
    end
    rl_step(1'b0, "R10 fall ignored", 1'b0);
    rl_step(1'b1, "R10 first rise", 1'b1);
  endtask

  task automatic t_basic;
    set_mode(1'b0, 1'b1, 1'b1);
    do_load(8'd3);
    for (int i = 1; i <= 7; i++) begin
      car_step("R1 basic", exp_hit(i, 3, 3));
      if (i == 3) begin
        @(negedge clk);
        check("R7 one clock", irq_pulse, 1'b0);
      end
    end
    rl_step(1'b0, "R1 reload ignored", 1'b0);
    rl_step(1'b1, "R1 reload ignored", 1'b0);
    rl_step(1'b0, "R1 reload ignored", 1'b0);
    rl_step(1'b1, "R1 reload ignored", 1'b0);
    car_step("R1 basic", 1'b0);
    car_step("R1 basic", 1'b1);
  endtask

  task automatic t_ext_carrier;
    set_mode(1'b1, 1'b0, 1'b1);
    do_load(8'd4);
    for (int i = 1; i <= 8; i++) car_step("R2 ext carrier", exp_hit(i, 4, 4));
  endtask

  task automatic t_rise;
    set_mode(1'b1, 1'b1, 1'b0);
    do_load(8'd3);
    for (int r = 1; r <= 6; r++) begin
      rl_step(1'b0, "R3 fall ignored", 1'b0);
      rl_step(1'b1, "R3 rise", exp_hit(r, 3, 3));
    end
    for (int i = 0; i < 5; i++) car_step("R3 carrier ignored", 1'b0);
    rl_step(1'b0, "R3", 1'b0);
    rl_step(1'b1, "R3", 1'b0);
    rl_step(1'b0, "R3", 1'b0);
    rl_step(1'b1, "R3", 1'b0);
    rl_step(1'b0, "R3", 1'b0);
    rl_step(1'b1, "R3 third rise", 1'b1);
  endtask

  task automatic t_fall;
    set_mode(1'b1, 1'b1, 1'b1);
    do_load(8'd4);
    for (int f = 1; f <= 11; f++) begin
      rl_step(1'b0, "R5 fall short first", exp_hit(f, 3, 4));
      rl_step(1'b1, "R4 rise ignored", 1'b0);
    end
  endtask

  task automatic t_zero;
    do_load(8'd0);
    for (int f = 0; f < 3; f++) begin
      rl_step(1'b0, "R6 zero as one", 1'b1);
      rl_step(1'b1, "R6 rise ignored", 1'b0);
    end
    set_mode(1'b0, 1'b0, 1'b0);
    do_load(8'd0);
    for (int i = 0; i < 3; i++) car_step("R6 zero as one basic", 1'b1);
  endtask

  task automatic t_disable;
    set_mode(1'b0, 1'b0, 1'b0);
    do_load(8'd3);
    car_step("R8", 1'b0);
    car_step("R8", 1'b0);
    @(negedge clk) func_en = 1'b0;
    for (int i = 0; i < 3; i++) car_step("R8 disabled", 1'b0);
    @(negedge clk) func_en = 1'b1;
    car_step("R8 cleared", 1'b0);
    car_step("R8 cleared", 1'b0);
    car_step("R8 cleared", 1'b1);
    set_mode(1'b1, 1'b1, 1'b1);
    do_load(8'd3);
    rl_step(1'b0, "R8 short", 1'b0);
    rl_step(1'b1, "R8", 1'b0);
    rl_step(1'b0, "R8 short", 1'b1);
    rl_step(1'b1, "R8", 1'b0);
    rl_step(1'b0, "R8 full", 1'b0);
    rl_step(1'b1, "R8", 1'b0);
    rl_step(1'b0, "R8 full", 1'b0);
    rl_step(1'b1, "R8", 1'b0);
    @(negedge clk) func_en = 1'b0;
    rl_step(1'b0, "R8 disabled", 1'b0);
    rl_step(1'b1, "R8 disabled", 1'b0);
    @(negedge clk) func_en = 1'b1;
    rl_step(1'b0, "R8 rearmed", 1'b0);
    rl_step(1'b1, "R8", 1'b0);
    rl_step(1'b0, "R8 rearmed short", 1'b1);
  endtask

  task automatic t_load;
    set_mode(1'b0, 1'b0, 1'b0);
    do_load(8'd2);
    car_step("R9", 1'b0);
    @(negedge clk) cnt_val = 8'd2; cnt_load = 1'b1; car_uflow = 1'b1;
    @(negedge clk) cnt_load = 1'b0; car_uflow = 1'b0;
    check("R9 event in load dropped", irq_pulse, 1'b0);
    car_step("R9 restart", 1'b0);
    car_step("R9 restart", 1'b1);
  endtask

  initial begin
    #(CLK_P * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0; func_en = 1'b1; ext_mode = 1'b1; src_sel = 1'b1; edge_pol = 1'b0;
    cnt_load = 1'b0; car_uflow = 1'b0; reload_sig = 1'b1; cnt_val = 8'd1;
    t_reset();
    t_basic();
    t_ext_carrier();
    t_rise();
    t_fall();
    t_zero();
    t_disable();
    t_load();
    repeat (2) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule